// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A register-mapped timer with a parameterised number of identical 32-bit channels that count downward. Each channel holds a configuration word, an interval word and a live count. A channel steps its count on ticks from one of four tick-enable inputs, divided by a power-of-two prescaler. When a step is taken while the count is already zero, the channel expires. An expiry sets the channel's pending-event bit, and the channel then either reloads and continues (periodic) or halts (single-shot). All tick sources are enables in the single clock domain of the block.

Software reaches the block over a plain synchronous bus: address, write strobe, write data and a combinational read word. One shared word masks the event bits onto a single interrupt line. A second shared word holds the pending-event bits, and writing a 1 to a bit clears it. Clearing a channel's run bit does not halt it at once. The channel goes on stepping for a fixed number of ticks of its chosen source, which mimics the stop latency of a timer clocked from a slow source.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq_o` is low.
- R2: The map is mask word at 0x00 and event word at 0x04, where bit n belongs to channel n. Channel n has its configuration word at 0x10·n+0x10, its interval at 0x10·n+0x14 and its count at 0x10·n+0x18. Every other address, and every channel index at or above the channel count, reads 0.
- R3: The configuration word has run at bit 0, load at bit 1, source select at bits 3:2, prescale code at bits 6:4 and single-shot at bit 7. A write with bit 1 set copies the interval into the count, and the new count reads back on the next cycle. Bit 1 always reads 0.
- R4: An active channel takes one step on every 2^code-th tick of `src_tick_i[sel]`. A step at a nonzero count lowers the count by 1.
- R5: A step at count 0 is an expiry, and it sets the channel's event bit. With bit 7 clear, the count reloads from the interval, so the period is interval+1 steps.
- R6: With bit 7 set, an expiry leaves the count at 0 and clears the run bit. The channel takes no further steps.
- R7: Writing run=0 to a running channel keeps it active for exactly 2 more ticks of its selected source, and each of those ticks is prescaled as usual. The count is frozen after that.
- R8: Writing 1 to an event bit clears it, and writing 0 has no effect. If an expiry happens in the same cycle as the clear, the bit stays set.
- R9: `irq_o` is high exactly when some channel has both its event bit and its mask bit set.
- R10: Ticks on unselected sources have no effect, and neither do ticks reaching an idle channel. An inactive channel's count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| src_tick_i | input | 4 | Tick enables of the four clock sources |
| bus_rdata_o | output | 32 | Read word for `bus_addr_i`, combinational |
| irq_o | output | 1 | Masked OR of all event bits |

## Verification
The hardest state to reach is the collision of an expiry with a software write in the same cycle. This covers a clear of the event bit while the channel expires, and a run-bit clear that opens the stop window while ticks keep arriving. Directed phases create both cases on purpose. A zero interval on an always-ticking source makes the channel expire every cycle, so any clear write collides with an expiry. The stop window is then probed with single manual ticks. A long random phase mixes writes and ticks on all four sources, and a behavioural model is compared with every read word and with the interrupt line on each cycle.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types of the down-counting timer.
// Assumes 32-bit registers and byte addressing with a 16-byte channel stride.
package tick_timer_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned SRC_W     = 2;
    localparam int unsigned PRE_W     = 3;
    localparam int unsigned NUM_SRC   = 2 ** SRC_W;
    localparam int unsigned OFF_IEN   = 'h00;
    localparam int unsigned OFF_STAT  = 'h04;
    localparam int unsigned CH_STRIDE = 'h10;
    localparam int unsigned OFF_CTRL  = 'h0;
    localparam int unsigned OFF_IVAL  = 'h4;
    localparam int unsigned OFF_CNT   = 'h8;
    localparam int unsigned BIT_RUN   = 0;
    localparam int unsigned BIT_LOAD  = 1;
    localparam int unsigned BIT_SRC   = 2;
    localparam int unsigned BIT_PRE   = 4;
    localparam int unsigned BIT_SHOT  = 7;

    typedef struct packed {
        logic             shot;
        logic [PRE_W-1:0] pre;
        logic [SRC_W-1:0] src;
        logic             run;
    } chan_cfg_t;

    // Unpacks a written configuration word (load bit is not stored).
    function automatic chan_cfg_t cfg_from_word(logic [DW-1:0] w);
        chan_cfg_t c;
        c.shot = w[BIT_SHOT];
        c.pre  = w[BIT_PRE +: PRE_W];
        c.src  = w[BIT_SRC +: SRC_W];
        c.run  = w[BIT_RUN];
        return c;
    endfunction

    // Packs a configuration for read-back; the load bit always reads 0.
    function automatic logic [DW-1:0] cfg_to_word(chan_cfg_t c);
        return {{(DW-8){1'b0}}, c.shot, c.pre, c.src, 1'b0, c.run};
    endfunction
endpackage

// File: rtl/tick_timer_presc.sv
// Power-of-two tick divider of one channel.
// Emits a step on every 2^code-th advance; the code may change at any time,
// in which case the accumulator runs on and wraps before matching again.
module tick_timer_presc #(
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [PRE_W-1:0] code_i,
    output logic             step_o
);
    localparam int unsigned CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] limit;

    assign limit  = ~({CNT_W{1'b1}} << code_i);
    assign step_o = adv_i && (acc_q == limit);

    // Accumulates source ticks; restarts on a step or a load.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr_i)  acc_q <= '0;
        else if (adv_i)  acc_q <= step_o ? '0 : acc_q + CNT_W'(1);
    end

    p_presc_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !step_o && !clr_i) |=> (acc_q == $past(acc_q) + CNT_W'(1)));
endmodule

// File: rtl/tick_timer_chan.sv
// One timer channel: configuration, interval, down-counter and stop window.
// Assumes ticks are single-cycle enables in the clk domain; a write to the
// configuration word takes priority over any same-cycle expiry effect.
module tick_timer_chan
    import tick_timer_pkg::*;
#(
    parameter int unsigned STOP_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic               ival_we_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [NUM_SRC-1:0] src_tick_i,
    output chan_cfg_t          cfg_o,
    output logic [DW-1:0]      ival_o,
    output logic [DW-1:0]      cnt_o,
    output logic               expire_o
);
    localparam int unsigned STOP_W = $clog2(STOP_TICKS + 1);

    chan_cfg_t         cfg_q;
    logic [DW-1:0]     ival_q;
    logic [DW-1:0]     cnt_q;
    logic [STOP_W-1:0] stop_q;
    logic [STOP_W-1:0] stop_auto;
    logic              load_req;
    logic              active;
    logic              adv;
    logic              step;
    logic              at_zero;

    assign load_req = cfg_we_i && wdata_i[BIT_LOAD];
    assign active   = cfg_q.run || (stop_q != '0);
    assign adv      = active && src_tick_i[cfg_q.src];
    assign at_zero  = (cnt_q == '0);
    assign expire_o = step && at_zero;

    tick_timer_presc #(.PRE_W(PRE_W)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (load_req),
        .adv_i  (adv),
        .code_i (cfg_q.pre),
        .step_o (step)
    );

    // Stop window as it evolves without a configuration write.
    always_comb begin
        if (expire_o && cfg_q.shot)     stop_auto = '0;
        else if (adv && stop_q != '0)   stop_auto = stop_q - STOP_W'(1);
        else                            stop_auto = stop_q;
    end

    // Configuration word; a single-shot expiry drops the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cfg_q <= '0;
        else if (cfg_we_i)               cfg_q <= cfg_from_word(wdata_i);
        else if (expire_o && cfg_q.shot) cfg_q.run <= 1'b0;
    end

    // Stop window: opened when a running channel is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n)                                stop_q <= '0;
        else if (cfg_we_i && wdata_i[BIT_RUN])     stop_q <= '0;
        else if (cfg_we_i && cfg_q.run)            stop_q <= STOP_W'(STOP_TICKS);
        else                                       stop_q <= stop_auto;
    end

    // Interval word, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)         ival_q <= '0;
        else if (ival_we_i) ival_q <= wdata_i;
    end

    // Down-counter: load, step, or reload/hold on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (load_req)  cnt_q <= ival_q;
        else if (step) begin
            if (!at_zero)         cnt_q <= cnt_q - DW'(1);
            else if (!cfg_q.shot) cnt_q <= ival_q;
        end
    end

    assign cfg_o  = cfg_q;
    assign ival_o = ival_q;
    assign cnt_o  = cnt_q;

    p_reload_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (cnt_q == $past(ival_q)));
    p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_zero && !load_req) |=> (cnt_q == $past(cnt_q) - DW'(1)));
    p_oneshot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && cfg_q.shot && !cfg_we_i) |=> (!cfg_q.run && cnt_q == '0));
    p_stop_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q <= STOP_W'(STOP_TICKS)));
    p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load_req) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_irq.sv
// Shared mask and pending-event words plus the interrupt line.
// Assumes expiry pulses last one cycle; a pulse beats a same-cycle clear.
module tick_timer_irq #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_we_i,
    input  logic              stat_we_i,
    input  logic [NUM_CH-1:0] wmask_i,
    input  logic [NUM_CH-1:0] expire_i,
    output logic [NUM_CH-1:0] ien_o,
    output logic [NUM_CH-1:0] stat_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] ien_q;
    logic [NUM_CH-1:0] stat_q;

    // Mask word, plain write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_q <= '0;
        else if (ien_we_i) ien_q <= wmask_i;
    end

    // Event word: write-one-to-clear, expiry sets with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_we_i ? (stat_q & ~wmask_i) : stat_q) | expire_i;
    end

    assign irq_o  = |(stat_q & ien_q);
    assign ien_o  = ien_q;
    assign stat_o = stat_q;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            expire_i[n] |=> stat_q[n]);
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we_i && wmask_i[n] && !expire_i[n]) |=> !stat_q[n]);
    end
endmodule

// File: rtl/tick_timer.sv
// Top of the multi-channel down-counting timer: address decode, read mux,
// channel array and interrupt collection. Assumes word-aligned accesses and
// that 0x10*(NUM_CH+1) fits in ADDR_W bits.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned STOP_TICKS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_we_i,
    input  logic [DW-1:0]      bus_wdata_i,
    input  logic [NUM_SRC-1:0] src_tick_i,
    output logic [DW-1:0]      bus_rdata_o,
    output logic               irq_o
);
    logic [NUM_CH-1:0] cfg_we;
    logic [NUM_CH-1:0] ival_we;
    logic [NUM_CH-1:0] expire;
    logic [NUM_CH-1:0] ien;
    logic [NUM_CH-1:0] stat;
    chan_cfg_t         cfg_arr  [NUM_CH];
    logic [DW-1:0]     ival_arr [NUM_CH];
    logic [DW-1:0]     cnt_arr  [NUM_CH];
    logic              ien_we;
    logic              stat_we;

    assign ien_we  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_IEN));
    assign stat_we = bus_we_i && (bus_addr_i == ADDR_W'(OFF_STAT));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned BASE = CH_STRIDE * (c + 1);

        assign cfg_we[c]  = bus_we_i && (bus_addr_i == ADDR_W'(BASE + OFF_CTRL));
        assign ival_we[c] = bus_we_i && (bus_addr_i == ADDR_W'(BASE + OFF_IVAL));

        tick_timer_chan #(.STOP_TICKS(STOP_TICKS)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we_i   (cfg_we[c]),
            .ival_we_i  (ival_we[c]),
            .wdata_i    (bus_wdata_i),
            .src_tick_i (src_tick_i),
            .cfg_o      (cfg_arr[c]),
            .ival_o     (ival_arr[c]),
            .cnt_o      (cnt_arr[c]),
            .expire_o   (expire[c])
        );
    end

    tick_timer_irq #(.NUM_CH(NUM_CH)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ien_we_i  (ien_we),
        .stat_we_i (stat_we),
        .wmask_i   (bus_wdata_i[NUM_CH-1:0]),
        .expire_i  (expire),
        .ien_o     (ien),
        .stat_o    (stat),
        .irq_o     (irq_o)
    );

    // Read mux: selects the addressed word, unmapped addresses give 0.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFF_IEN))  bus_rdata_o = DW'(ien);
        if (bus_addr_i == ADDR_W'(OFF_STAT)) bus_rdata_o = DW'(stat);
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr_i == ADDR_W'(CH_STRIDE * (c + 1) + OFF_CTRL)) bus_rdata_o = cfg_to_word(cfg_arr[c]);
            if (bus_addr_i == ADDR_W'(CH_STRIDE * (c + 1) + OFF_IVAL)) bus_rdata_o = ival_arr[c];
            if (bus_addr_i == ADDR_W'(CH_STRIDE * (c + 1) + OFF_CNT))  bus_rdata_o = cnt_arr[c];
        end
    end
endmodule

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/100ps
module tick_timer_tb_top;
    localparam int NCH = 2;
    localparam int STOPN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  src_tick = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tick_timer #(.NUM_CH(NCH), .ADDR_W(8), .STOP_TICKS(STOPN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
        .bus_wdata_i(bus_wdata), .src_tick_i(src_tick),
        .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    int unsigned m_cnt [NCH];
    int unsigned m_ival[NCH];
    int          m_pc  [NCH];
    int          m_stop[NCH];
    int          m_src [NCH];
    int          m_pre [NCH];
    bit          m_en  [NCH];
    bit          m_os  [NCH];
    logic [NCH-1:0] m_ien;
    logic [NCH-1:0] m_stat;

    always @(posedge clk) begin
        logic [NCH-1:0] fired;
        bit en_before, act, stp, tk;
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_ival[c] = 0; m_pc[c] = 0; m_stop[c] = 0;
                m_src[c] = 0; m_pre[c] = 0; m_en[c] = 0; m_os[c] = 0;
            end
            m_ien = '0; m_stat = '0;
        end else begin
            fired = '0;
            for (int c = 0; c < NCH; c++) begin
                en_before = m_en[c];
                tk  = src_tick[m_src[c]];
                act = m_en[c] || (m_stop[c] != 0);
                stp = 0;
                if (act && tk) begin
                    if (m_pc[c] == (1 << m_pre[c]) - 1) begin stp = 1; m_pc[c] = 0; end
                    else m_pc[c] = (m_pc[c] + 1) % 128;
                    if (m_stop[c] != 0) m_stop[c] = m_stop[c] - 1;
                end
                if (stp) begin
                    if (m_cnt[c] == 0) begin
                        fired[c] = 1'b1;
                        if (m_os[c]) begin m_en[c] = 0; m_stop[c] = 0; end
                        else m_cnt[c] = m_ival[c];
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
                if (bus_we && bus_addr == 8'(16 * (c + 1))) begin
                    m_en[c]  = bus_wdata[0];
                    m_src[c] = int'(bus_wdata[3:2]);
                    m_pre[c] = int'(bus_wdata[6:4]);
                    m_os[c]  = bus_wdata[7];
                    if (bus_wdata[0]) m_stop[c] = 0;
                    else if (en_before) m_stop[c] = STOPN;
                    if (bus_wdata[1]) begin m_cnt[c] = m_ival[c]; m_pc[c] = 0; end
                end
                if (bus_we && bus_addr == 8'(16 * (c + 1) + 4)) m_ival[c] = bus_wdata;
            end
            if (bus_we && bus_addr == 8'h00) m_ien = bus_wdata[NCH-1:0];
            if (bus_we && bus_addr == 8'h04) m_stat = m_stat & ~bus_wdata[NCH-1:0];
            m_stat = m_stat | fired;
        end
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) r = 32'(m_ien);
        if (a == 8'h04) r = 32'(m_stat);
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(16 * (c + 1)))
                r = {24'd0, m_os[c], 3'(m_pre[c]), 2'(m_src[c]), 1'b0, m_en[c]};
            if (a == 8'(16 * (c + 1) + 4)) r = m_ival[c];
            if (a == 8'(16 * (c + 1) + 8)) r = m_cnt[c];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Model comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq vs model", 32'(irq), 32'(|(m_stat & m_ien)));
            if (!bus_we) chk("R2 read vs model", bus_rdata, exp_rd(bus_addr));
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [31:0] mask, logic [31:0] exp, string tag);
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata & mask, exp);
    endtask

    task automatic man_tick(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1; src_tick[2] = 1'b1;
            @(posedge clk); #1; src_tick[2] = 1'b0;
        end
    endtask

    task automatic free_run(int n);
        @(posedge clk); #1; src_tick[0] = 1'b1;
        repeat (n) @(posedge clk);
        #1; src_tick[0] = 1'b0;
    endtask

    initial begin
        logic [7:0] ra;
        logic [31:0] rw;
        repeat (4) @(posedge clk);
        #1; rst_n = 1'b1;

        // R1: reset state
        rd_chk(8'h00, '1, 32'h0, "R1 mask after reset");
        rd_chk(8'h04, '1, 32'h0, "R1 events after reset");
        rd_chk(8'h10, '1, 32'h0, "R1 config after reset");
        rd_chk(8'h28, '1, 32'h0, "R1 count after reset");
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R3: load on start, load bit reads 0 (src=2, pre=0, periodic)
        wr(8'h14, 32'd5);
        wr(8'h10, 32'h0B);
        rd_chk(8'h10, '1, 32'h09, "R3 load bit reads 0");
        rd_chk(8'h18, '1, 32'd5, "R3 count loaded");

        // R4: three steps
        man_tick(3);
        rd_chk(8'h18, '1, 32'd2, "R4 count after 3 ticks");

        // R10: unselected source and idle channel ignore ticks
        free_run(5);
        rd_chk(8'h18, '1, 32'd2, "R10 unselected source ignored");
        rd_chk(8'h28, '1, 32'd0, "R10 idle channel holds");

        // R5: expiry at zero reloads and flags
        man_tick(3);
        rd_chk(8'h18, '1, 32'd5, "R5 periodic reload");
        rd_chk(8'h04, '1, 32'h1, "R5 event bit set");
        chk("R9 masked off", 32'(irq), 32'h0);
        wr(8'h00, 32'h1);
        @(negedge clk);
        chk("R9 irq raised by mask", 32'(irq), 32'h1);

        // R8: write 0 no effect, write 1 clears
        wr(8'h04, 32'h0);
        rd_chk(8'h04, '1, 32'h1, "R8 write 0 keeps bit");
        wr(8'h04, 32'h1);
        rd_chk(8'h04, '1, 32'h0, "R8 write 1 clears bit");
        chk("R9 irq dropped", 32'(irq), 32'h0);

        // R4: prescale code 2 divides by 4
        wr(8'h24, 32'd100);
        wr(8'h20, 32'h2B);
        man_tick(8);
        rd_chk(8'h28, '1, 32'd98, "R4 prescaled steps");

        // R7: stop window of two source ticks
        wr(8'h20, 32'h09);
        wr(8'h20, 32'h08);
        rd_chk(8'h20, '1, 32'h08, "R7 run bit reads 0");
        man_tick(4);
        rd_chk(8'h28, '1, 32'd96, "R7 two more steps then frozen");

        // R6: single-shot
        wr(8'h24, 32'd2);
        wr(8'h20, 32'h8B);
        man_tick(3);
        rd_chk(8'h28, '1, 32'd0, "R6 count at zero");
        rd_chk(8'h20, '1, 32'h88, "R6 run bit cleared");
        rd_chk(8'h04, 32'h2, 32'h2, "R6 event bit set");
        man_tick(2);
        rd_chk(8'h28, '1, 32'd0, "R6 no further steps");

        // R4: free-running full-range counter
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, 32'h03);
        rd_chk(8'h18, '1, 32'hFFFF_FFFF, "R4 full-range load");
        free_run(10);
        rd_chk(8'h18, '1, 32'hFFFF_FFF5, "R4 ten free steps");

        // R8: expiry in the same cycle as clear wins
        wr(8'h14, 32'd0);
        wr(8'h10, 32'h03);
        @(posedge clk); #1; src_tick[0] = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        wr(8'h04, 32'h1);
        rd_chk(8'h04, 32'h1, 32'h1, "R8 set beats clear");
        src_tick[0] = 1'b0;
        wr(8'h04, 32'h3);
        rd_chk(8'h04, '1, 32'h0, "R8 cleared when idle");

        // R2: unmapped addresses
        rd_chk(8'h0C, '1, 32'h0, "R2 gap reads 0");
        rd_chk(8'h1C, '1, 32'h0, "R2 sub-offset 0xC reads 0");
        rd_chk(8'h30, '1, 32'h0, "R2 channel beyond count reads 0");

        // Random phase, compared against the model every clock
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            src_tick = 4'($urandom);
            case ($urandom % 10)
                0: ra = 8'h00; 1: ra = 8'h04; 2: ra = 8'h0C; 3: ra = 8'h10;
                4: ra = 8'h14; 5: ra = 8'h18; 6: ra = 8'h20; 7: ra = 8'h24;
                8: ra = 8'h28; default: ra = 8'h30;
            endcase
            rw = $urandom;
            if (ra == 8'h14 || ra == 8'h24) rw = rw % 6;
            if (ra == 8'h10 || ra == 8'h20) rw = rw & 32'h0000_00BF;
            bus_addr  = ra;
            bus_wdata = rw;
            bus_we    = (($urandom % 6) == 0);
        end
        @(posedge clk); #1;
        bus_we = 1'b0;
        src_tick = '0;
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule